// File: doc/BRIEF.md
# Two-Level Tag Table Engine

This engine keeps one tag bit per memory word in ordinary memory and hides a two-level layout behind a flat tag space. A summary (root) bit stands for a group of GF tag bits held in the lower (leaf) level. A root bit of zero means the whole group holds zero. Reads and zero writes to such a group never touch the leaf level. A cleared root bit also means the leaf contents may be stale and must not be trusted.

Clients issue single-tag reads and writes by word index over a valid/ready port. Each request finishes with a one-cycle response. The engine reaches its table through a line-wide memory port with a request/acknowledge handshake. One memory line is exactly one leaf group. The address MSB selects the leaf region (1) or the root region (0). After reset the engine wipes only the root lines, which clears every tag in memory. Requests are accepted only after that.

Top module: `tag_hier_engine`

## Requirements
- R1: From reset, the engine writes all-zero data to each root line, at addresses 0 up to ceil(2^WORD_AW/GF^2)-1 with MSB 0. It makes no other memory access during this phase, and holds busy high and req_ready low until the last root write is acknowledged.
- R2: For every accepted request, the first memory access is a read of the root line at address {0, (idx/GF)/GF}. Bit (idx/GF) mod GF of that line is the group's root bit.
- R3: A read whose root bit is 0 returns tag 0 after exactly one memory access, whatever the leaf line holds.
- R4: A read whose root bit is 1 also reads leaf line {1, idx/GF} and returns its bit idx mod GF, for two accesses in all.
- R5: A write of 0 whose root bit is 0 completes after the root read alone and writes nothing.
- R6: A write of 1 whose root bit is 0 writes the leaf line with only the target bit set, which discards stale contents. It then writes the root line with the group's bit set, for three accesses.
- R7: A write whose root bit is 1 reads the leaf line and writes it back with only the target bit changed. It makes no root access after the first read.
- R8: When a write of 0 leaves its group all zero, the root line is then written with the group's bit cleared, for four accesses. If another bit in the group stays set, the root bit is kept.
- R9: A request is taken on a cycle with req_valid and req_ready both high, and req_ready stays low while busy. Each request yields exactly one rsp_valid pulse of one cycle. On a write, rsp_tag equals the value written.
- R10: Once mem_req is raised, mem_req, mem_we, mem_addr and mem_wdata stay unchanged until mem_ack.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | WORD_AW | Word index of the tag |
| req_tag | input | 1 | Tag value to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_tag | output | 1 | Tag read, or value written |
| busy | output | 1 | Root wipe or a request sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | WORD_AW-log2(GF)+1 | Line address; MSB selects leaf region |
| mem_wdata | output | GF | Line write data |
| mem_rdata | input | GF | Line read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle access completion |

## Verification
The assertions assume that the memory pulses mem_ack for a single cycle, and only while a request is pending. They also assume that mem_rdata is the current line content in that cycle. The bench memory model meets this by acknowledging each access on the second cycle it is seen. During that wait it compares the held request against its first sight. The stimulus starts with every leaf line filled with ones, so skipped or stale leaf data would show up in the returned tags. It offers a new request only after the previous response has been seen.

// File: rtl/tag_hier_pkg.sv
package tag_hier_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ROOT_RD,
    S_LEAF_RD,
    S_LEAF_WR,
    S_ROOT_WR,
    S_RESP
  } seq_st_t;
endpackage

// File: rtl/tag_hier_boot.sv
module tag_hier_boot #(
  parameter int ROOT_LINES = 1,
  parameter int ROOT_AW    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack,
  output logic               active,
  output logic [ROOT_AW-1:0] line
);
  localparam logic [ROOT_AW-1:0] LAST = ROOT_AW'(ROOT_LINES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line   <= '0;
      active <= 1'b1;
    end else if (active && ack) begin
      if (line == LAST) active <= 1'b0;
      else              line   <= line + 1'b1;
    end
  end
endmodule

// File: rtl/tag_hier_linemod.sv
module tag_hier_linemod #(
  parameter int GF   = 512,
  parameter int GF_W = 9
) (
  input  logic [GF-1:0]   line_in,
  input  logic [GF_W-1:0] sel,
  input  logic            val,
  output logic [GF-1:0]   line_out,
  output logic            bit_old
);
  always_comb begin
    line_out      = line_in;
    line_out[sel] = val;
    bit_old       = line_in[sel];
  end
endmodule

// File: rtl/tag_hier_seq.sv
module tag_hier_seq
  import tag_hier_pkg::*;
#(
  parameter int WORD_AW  = 16,
  parameter int GF       = 512,
  parameter int GF_W     = 9,
  parameter int GROUP_AW = 7,
  parameter int MEM_AW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               req_write,
  input  logic [WORD_AW-1:0] req_idx,
  input  logic               req_tag,
  output logic               busy,
  output logic               rsp_valid,
  output logic               rsp_tag,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [GF-1:0]      mem_wdata,
  input  logic [GF-1:0]      mem_rdata,
  input  logic               ack,
  output logic               ev_root_zero,
  output logic               ev_group_empty,
  output logic               cur_wr,
  output logic               cur_val
);
  function automatic logic [GROUP_AW-1:0] group_of(input logic [WORD_AW-1:0] w);
    return w[WORD_AW-1:GF_W];
  endfunction

  function automatic logic [MEM_AW-1:0] root_addr(input logic [GROUP_AW-1:0] g);
    return {1'b0, g >> GF_W};
  endfunction

  function automatic logic [GF_W-1:0] root_bit(input logic [GROUP_AW-1:0] g);
    logic [GROUP_AW+GF_W-1:0] wide;
    wide = {{GF_W{1'b0}}, g};
    return wide[GF_W-1:0];
  endfunction

  function automatic logic [MEM_AW-1:0] leaf_addr(input logic [GROUP_AW-1:0] g);
    return {1'b1, g};
  endfunction

  seq_st_t             st;
  logic [WORD_AW-1:0]  idx_q;
  logic                wr_q, val_q, tag_q, root_upd_q;
  logic [GF-1:0]       root_q, leaf_q;

  logic [GROUP_AW-1:0] grp;
  logic [GF-1:0]       leaf_in, leaf_new, root_in, root_new;
  logic                leaf_old_bit, root_hit, leaf_new_zero;

  assign grp = group_of(idx_q);
  assign leaf_in = (st == S_ROOT_RD) ? '0 : mem_rdata;
  assign root_in = (st == S_ROOT_RD) ? mem_rdata : root_q;

  tag_hier_linemod #(.GF(GF), .GF_W(GF_W)) u_leaf_mod (
    .line_in(leaf_in), .sel(idx_q[GF_W-1:0]), .val(val_q),
    .line_out(leaf_new), .bit_old(leaf_old_bit)
  );

  tag_hier_linemod #(.GF(GF), .GF_W(GF_W)) u_root_mod (
    .line_in(root_in), .sel(root_bit(grp)), .val(val_q),
    .line_out(root_new), .bit_old(root_hit)
  );

  assign leaf_new_zero  = ~|leaf_new;
  assign ev_root_zero   = (st == S_ROOT_RD) && ack && !root_hit;
  assign ev_group_empty = (st == S_LEAF_RD) && ack && wr_q && !val_q && leaf_new_zero;
  assign cur_wr         = wr_q;
  assign cur_val        = val_q;

  assign busy      = (st != S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_tag   = tag_q;
  assign mem_req   = (st == S_ROOT_RD) || (st == S_LEAF_RD) ||
                     (st == S_LEAF_WR) || (st == S_ROOT_WR);
  assign mem_we    = (st == S_LEAF_WR) || (st == S_ROOT_WR);
  assign mem_addr  = ((st == S_ROOT_RD) || (st == S_ROOT_WR)) ? root_addr(grp) : leaf_addr(grp);
  assign mem_wdata = (st == S_ROOT_WR) ? root_new : ((st == S_LEAF_WR) ? leaf_q : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx_q      <= '0;
      wr_q       <= 1'b0;
      val_q      <= 1'b0;
      tag_q      <= 1'b0;
      root_upd_q <= 1'b0;
      root_q     <= '0;
      leaf_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          idx_q      <= req_idx;
          wr_q       <= req_write;
          val_q      <= req_tag;
          tag_q      <= req_write & req_tag;
          root_upd_q <= 1'b0;
          st         <= S_ROOT_RD;
        end
        S_ROOT_RD: if (ack) begin
          root_q <= mem_rdata;
          if (root_hit) begin
            st <= S_LEAF_RD;
          end else if (wr_q && val_q) begin
            leaf_q     <= leaf_new;
            root_upd_q <= 1'b1;
            st         <= S_LEAF_WR;
          end else begin
            st <= S_RESP;
          end
        end
        S_LEAF_RD: if (ack) begin
          if (!wr_q) begin
            tag_q <= leaf_old_bit;
            st    <= S_RESP;
          end else begin
            leaf_q     <= leaf_new;
            root_upd_q <= !val_q && leaf_new_zero;
            st         <= S_LEAF_WR;
          end
        end
        S_LEAF_WR: if (ack) st <= root_upd_q ? S_ROOT_WR : S_RESP;
        S_ROOT_WR: if (ack) st <= S_RESP;
        S_RESP:    st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tag_hier_engine.sv
module tag_hier_engine #(
  parameter int WORD_AW = 16,
  parameter int GF      = 512,
  localparam int GF_W       = $clog2(GF),
  localparam int GROUP_AW   = WORD_AW - GF_W,
  localparam int NGROUPS    = 1 << GROUP_AW,
  localparam int ROOT_LINES = (NGROUPS + GF - 1) / GF,
  localparam int ROOT_AW    = (ROOT_LINES > 1) ? $clog2(ROOT_LINES) : 1,
  localparam int MEM_AW     = GROUP_AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [WORD_AW-1:0] req_idx,
  input  logic               req_tag,
  output logic               rsp_valid,
  output logic               rsp_tag,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [GF-1:0]      mem_wdata,
  input  logic [GF-1:0]      mem_rdata,
  input  logic               mem_ack
);
  logic               boot_active;
  logic [ROOT_AW-1:0] boot_line;
  logic               seq_busy, seq_req, seq_we;
  logic [MEM_AW-1:0]  seq_addr;
  logic [GF-1:0]      seq_wdata;
  logic               ev_accept, ev_root_zero, ev_group_empty, cur_wr, cur_val;

  tag_hier_boot #(.ROOT_LINES(ROOT_LINES), .ROOT_AW(ROOT_AW)) u_boot (
    .clk(clk), .rst_n(rst_n), .ack(mem_ack && boot_active),
    .active(boot_active), .line(boot_line)
  );

  assign busy      = boot_active || seq_busy;
  assign req_ready = !busy;
  assign ev_accept = req_valid && req_ready;

  tag_hier_seq #(
    .WORD_AW(WORD_AW), .GF(GF), .GF_W(GF_W), .GROUP_AW(GROUP_AW), .MEM_AW(MEM_AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(ev_accept),
    .req_write(req_write), .req_idx(req_idx), .req_tag(req_tag),
    .busy(seq_busy), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .mem_req(seq_req), .mem_we(seq_we), .mem_addr(seq_addr), .mem_wdata(seq_wdata),
    .mem_rdata(mem_rdata), .ack(mem_ack && !boot_active),
    .ev_root_zero(ev_root_zero), .ev_group_empty(ev_group_empty),
    .cur_wr(cur_wr), .cur_val(cur_val)
  );

  assign mem_req   = boot_active ? 1'b1 : seq_req;
  assign mem_we    = boot_active ? 1'b1 : seq_we;
  assign mem_addr  = boot_active ? {1'b0, GROUP_AW'(boot_line)} : seq_addr;
  assign mem_wdata = boot_active ? '0 : seq_wdata;
endmodule

// File: rtl/tag_hier_engine_chk.sv
module tag_hier_engine_chk #(
  parameter int MEM_AW = 8,
  parameter int GF     = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              boot_active,
  input logic              ev_accept,
  input logic              ev_root_zero,
  input logic              ev_group_empty,
  input logic              cur_wr,
  input logic              cur_val,
  input logic              rsp_valid,
  input logic              rsp_tag,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [GF-1:0]     mem_wdata
);
  a_r1_boot_root_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    boot_active && mem_req |-> mem_we && !mem_addr[MEM_AW-1] && (mem_wdata == '0));

  a_r1_boot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    boot_active |-> !req_ready);

  a_r2_root_first: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> mem_req && !mem_we && !mem_addr[MEM_AW-1]);

  a_r3_read_skip: assert property (@(posedge clk) disable iff (!rst_n)
    ev_root_zero && !cur_wr |=> rsp_valid && !rsp_tag);

  a_r5_zero_write_skip: assert property (@(posedge clk) disable iff (!rst_n)
    ev_root_zero && cur_wr && !cur_val |=> rsp_valid && !mem_req);

  a_r6_fresh_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ev_root_zero && cur_wr && cur_val |=>
      mem_req && mem_we && mem_addr[MEM_AW-1] && ($countones(mem_wdata) == 1));

  a_r8_empty_leaf_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_group_empty |=> mem_req && mem_we && mem_addr[MEM_AW-1] && (mem_wdata == '0));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
endmodule

bind tag_hier_engine tag_hier_engine_chk #(.MEM_AW(MEM_AW), .GF(GF)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .boot_active(boot_active),
  .ev_accept(ev_accept), .ev_root_zero(ev_root_zero), .ev_group_empty(ev_group_empty),
  .cur_wr(cur_wr), .cur_val(cur_val), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tag_hier_engine_tb_top.sv
module tag_hier_engine_tb_top;
  localparam int WORD_AW = 16;
  localparam int GF      = 512;
  localparam int MEM_AW  = 8;
  localparam int NLINES  = 256;
  localparam int NVEC    = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_tag = 1'b0;
  logic [WORD_AW-1:0] req_idx = '0;
  logic req_ready, rsp_valid, rsp_tag, busy, mem_req, mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [GF-1:0] mem_wdata;
  logic [GF-1:0] mem_rdata;
  logic mem_ack;

  logic [GF-1:0] mem [NLINES];
  logic pend;
  logic [MEM_AW-1:0] h_addr;
  logic h_we;
  logic [GF-1:0] h_wd;
  int acc_cnt, wr_cnt, hold_err, rsp_cnt;
  logic [MEM_AW-1:0] log_addr [8];
  logic log_we [8];

  int errors = 0;
  int checks = 0;
  int reqs = 0;

  always #5 clk = ~clk;

  tag_hier_engine #(.WORD_AW(WORD_AW), .GF(GF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_idx(req_idx), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // Memory model: acknowledges on the second cycle a request is seen.
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; pend <= 1'b0; mem_rdata <= '0;
      acc_cnt <= 0; wr_cnt <= 0; hold_err <= 0; rsp_cnt <= 0;
      for (int i = 0; i < NLINES; i++) mem[i] <= '1;
    end else begin
      mem_ack <= 1'b0;
      if (rsp_valid) rsp_cnt <= rsp_cnt + 1;
      if (mem_req && !mem_ack) begin
        if (!pend) begin
          pend <= 1'b1; h_addr <= mem_addr; h_we <= mem_we; h_wd <= mem_wdata;
        end else begin
          if (mem_addr != h_addr || mem_we != h_we || mem_wdata != h_wd)
            hold_err <= hold_err + 1;
          pend      <= 1'b0;
          mem_ack   <= 1'b1;
          mem_rdata <= mem[mem_addr];
          if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
          end
          log_addr[acc_cnt[2:0]] <= mem_addr;
          log_we[acc_cnt[2:0]]   <= mem_we;
          acc_cnt <= acc_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_req(input logic w, input logic [WORD_AW-1:0] ix, input logic t,
                         output logic got, output int nacc, output int first);
    int start;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start = acc_cnt;
    req_valid = 1'b1; req_write = w; req_idx = ix; req_tag = t;
    @(negedge clk);
    req_valid = 1'b0;
    reqs++;
    while (!rsp_valid) @(negedge clk);
    got = rsp_tag;
    nacc = acc_cnt - start;
    first = start;
    @(negedge clk);
    chk(!rsp_valid, "R9 pulse length", rsp_valid, 0);
  endtask

  // {req[25:22], write[21], idx[20:5], tag[4], expected tag[3], accesses[2:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {4'd3, 1'b0, 16'h0005, 1'b0, 1'b0, 3'd1},  // R3 read, group 0 empty
    {4'd5, 1'b1, 16'h0005, 1'b0, 1'b0, 3'd1},  // R5 zero write, group 0 empty
    {4'd6, 1'b1, 16'h0205, 1'b1, 1'b1, 3'd3},  // R6 first set in group 1
    {4'd4, 1'b0, 16'h0205, 1'b0, 1'b1, 3'd2},  // R4 read back
    {4'd6, 1'b0, 16'h0206, 1'b0, 1'b0, 3'd2},  // R6 stale neighbour cleared
    {4'd7, 1'b1, 16'h03FF, 1'b1, 1'b1, 3'd3},  // R7 second set in group 1
    {4'd4, 1'b0, 16'h03FF, 1'b0, 1'b1, 3'd2},  // R4
    {4'd8, 1'b1, 16'h0205, 1'b0, 1'b0, 3'd3},  // R8 clear, group stays non-empty
    {4'd4, 1'b0, 16'h0205, 1'b0, 1'b0, 3'd2},  // R4
    {4'd7, 1'b0, 16'h03FF, 1'b0, 1'b1, 3'd2},  // R7 other bit preserved
    {4'd8, 1'b1, 16'h03FF, 1'b0, 1'b0, 3'd4},  // R8 last bit cleared
    {4'd8, 1'b0, 16'h03FF, 1'b0, 1'b0, 3'd1},  // R8 root now clear
    {4'd2, 1'b1, 16'hFFFF, 1'b1, 1'b1, 3'd3},  // R2 last group
    {4'd4, 1'b0, 16'hFFFF, 1'b0, 1'b1, 3'd2},  // R4
    {4'd6, 1'b0, 16'hFE00, 1'b0, 1'b0, 3'd2},  // R6 fill covers bit 0
    {4'd7, 1'b1, 16'hFFFF, 1'b1, 1'b1, 3'd3},  // R7 rewrite of a set tag
    {4'd3, 1'b0, 16'h0400, 1'b0, 1'b0, 3'd1}   // R3 stale ones in leaf ignored
  };

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy during wipe", busy, 1);
    chk(req_ready == 1'b0, "R1 ready during wipe", req_ready, 0);
    while (busy) @(negedge clk);
    chk(mem[0] == '0, "R1 root line wiped", mem[0][63:0], 0);
    chk(wr_cnt == 1, "R1 wipe write count", wr_cnt, 1);
    chk(mem[128] == '1, "R1 leaf untouched", mem[128][63:0], 64'hFFFFFFFFFFFFFFFF);

    for (int i = 0; i < NVEC; i++) begin
      logic got;
      int nacc, first;
      logic [25:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[25:22], i);
      run_req(v[21], v[20:5], v[4], got, nacc, first);
      chk(got == v[3], {tag, " tag"}, got, v[3]);
      chk(nacc == int'(v[2:0]), {tag, " accesses"}, nacc, v[2:0]);
      chk(log_addr[first[2:0]] == '0 && !log_we[first[2:0]], "R2 root read first",
          log_addr[first[2:0]], 0);
      if (i == 2) begin
        chk(log_addr[(first + 1) % 8] == 8'd129 && log_we[(first + 1) % 8],
            "R6 leaf write address", log_addr[(first + 1) % 8], 129);
        chk(mem[129] == (512'd1 << 5), "R6 one-hot leaf", mem[129][63:0], 64'h20);
        chk(mem[0][1] == 1'b1, "R6 root bit set", mem[0][1], 1);
      end
      if (i == 7) chk(mem[0][1] == 1'b1, "R8 root kept", mem[0][1], 1);
      if (i == 10) begin
        chk(mem[0][1] == 1'b0, "R8 root cleared", mem[0][1], 0);
        chk(mem[129] == '0, "R8 leaf zero", mem[129][63:0], 0);
      end
      if (i == 12) chk(mem[0][127] == 1'b1, "R2 root bit 127", mem[0][127], 1);
    end

    repeat (3) @(negedge clk);
    chk(rsp_cnt == reqs, "R9 one response per request", rsp_cnt, reqs);
    chk(hold_err == 0, "R10 request held until ack", hold_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule